// File: doc/BRIEF.md
# Banked Multi-Lane Scratchpad with Conflict Serialization

This block is an on-chip scratchpad shared by sixteen parallel requesters, called lanes, that present their accesses together as one group. Storage is split into sixteen banks of 32-bit words. The low four bits of a word address select the bank, so consecutive words fall in consecutive banks. Each bank can perform one access per clock. The block accepts a group in which every lane carries an enable, a word address, a read/write flag and write data. It then serves the group over as many cycles as the busiest bank needs.

In each service cycle, every bank serves the lowest-numbered lane that is still waiting on it. Any other waiting lanes that read that same word are served in the same access. The served lanes then drop out of the pending set. A group therefore finishes in as many cycles as the largest number of distinct words asked of any single bank. When all lanes read one word, that word is broadcast in a single cycle. While a group is in service the ready output stays low. When the last cycle ends, the block raises a one-cycle done pulse, and the read results for all lanes are presented together.

Top module: `sp_scratchpad`

## Requirements
- R1: The bank of a word address is its low 4 bits (address modulo 16) and the row within the bank is the remaining upper bits. A word written at an address is returned by a later read of that address.
- R2: A group whose active lanes all target different banks completes in one service cycle: done rises on the first clock edge after the accepting edge.
- R3: A group whose active lanes all read one identical address completes in one service cycle, and every such lane returns that word.
- R4: A group completes in N service cycles, where N is the largest number of distinct words requested from any single bank. Reads of an already-requested word add nothing to N. Done rises on the N-th clock edge after the accepting edge, and N never exceeds 16.
- R5: Lane addresses of the form base + stride x lane with an odd stride complete in one cycle. A stride of 2 takes 2 cycles, a stride of 4 takes 4 cycles, a stride of 8 takes 8 cycles and a stride of 16 takes 16 cycles.
- R6: When two lanes of one group write the same word, the data of the higher-numbered lane is the value stored.
- R7: A group is accepted only on an edge where req_valid and req_ready are both high. req_ready is low from the accepting edge until the edge that raises done. A request presented while req_ready is low has no effect on storage.
- R8: Lanes with their enable bit low take no part in conflict counting and return zero read data. Write lanes also return zero. A group with no enabled lane completes in one cycle.
- R9: rsp_done is high for exactly one cycle per group. rsp_rdata is cleared on acceptance and then holds the group's results unchanged until the next group is accepted.
- R10: While reset is held and after its release, req_ready is low during reset, rsp_done is low and rsp_rdata is zero. req_ready is high once reset has been released.
- R11: Conflicts are evaluated only within one group. A new group may be accepted in the same cycle that the previous group's done is high, and its service time depends only on its own addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request group is presented |
| req_ready | output | 1 | Block is idle and will accept a group on this edge |
| req_lane_en | input | 16 | Per-lane enable; bit i enables lane i |
| req_is_wr | input | 16 | Per-lane write flag; 1 = write, 0 = read |
| req_addr | input | 128 | Per-lane 8-bit word address; lane i at bits [8i+7:8i] |
| req_wdata | input | 512 | Per-lane 32-bit write data; lane i at bits [32i+31:32i] |
| rsp_done | output | 1 | One-cycle pulse when the group has been fully served |
| rsp_rdata | output | 512 | Per-lane read result; lane i at bits [32i+31:32i] |

## Verification
Completion of one group and acceptance of the next can fall on the same clock edge. The bench drives every new group at the falling edge of the cycle in which done is seen. Each group is therefore accepted exactly while the previous done pulse is high, including two same-bank groups issued back to back. A correct result shows each group taking only the cycles its own addresses imply, with the results of the earlier group intact at the moment of its pulse. Within one bank, a broadcast merge and the serialization of a different word also meet in one cycle. A mixed group, in which two lanes share a word and a third asks for another row of the same bank, is judged by its cycle count of two and by the data each lane receives.

// File: rtl/sp_pkg.sv
package sp_pkg;

  localparam int unsigned SP_LANES  = 16;
  localparam int unsigned SP_BANKS  = 16;
  localparam int unsigned SP_WORD_W = 32;
  localparam int unsigned SP_ADDR_W = 8;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } sp_state_e;

endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/sp_bank_pick.sv
module sp_bank_pick #(
  parameter int unsigned LANES    = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BSEL_W   = 4,
  parameter int unsigned BANK_IDX = 0,
  localparam int unsigned LIDX_W  = $clog2(LANES),
  localparam int unsigned ROW_W   = ADDR_W - BSEL_W
) (
  input  logic [LANES-1:0]             pend,
  input  logic [LANES-1:0][ADDR_W-1:0] addr,
  input  logic [LANES-1:0]             is_wr,
  output logic                         hit,
  output logic [LIDX_W-1:0]            lead,
  output logic [LANES-1:0]             grant,
  output logic [ROW_W-1:0]             row
);

  logic [LANES-1:0] match;

  // lanes still waiting on this bank
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      match[l] = pend[l] && (addr[l][BSEL_W-1:0] == BSEL_W'(BANK_IDX));
    end
  end

  // lowest waiting lane leads the access
  always_comb begin
    hit  = 1'b0;
    lead = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (match[l]) begin
        hit  = 1'b1;
        lead = LIDX_W'(l);
      end
    end
  end

  // readers of the leader's word ride along; writers go alone
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      grant[l] = match[l] &&
                 ((LIDX_W'(l) == lead) ||
                  (!is_wr[lead] && !is_wr[l] && (addr[l] == addr[lead])));
    end
  end

  assign row = addr[lead][ADDR_W-1:BSEL_W];

endmodule

// File: rtl/sp_bank_mem.sv
module sp_bank_mem #(
  parameter int unsigned ROWS   = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[row] <= wdata;
    end
  end

  assign rdata = mem[row];

endmodule

// File: rtl/sp_scratchpad.sv
module sp_scratchpad
  import sp_pkg::*;
#(
  parameter int unsigned LANES  = SP_LANES,
  parameter int unsigned BANKS  = SP_BANKS,
  parameter int unsigned WORD_W = SP_WORD_W,
  parameter int unsigned ADDR_W = SP_ADDR_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [LANES-1:0]         req_lane_en,
  input  logic [LANES-1:0]         req_is_wr,
  input  logic [LANES*ADDR_W-1:0]  req_addr,
  input  logic [LANES*WORD_W-1:0]  req_wdata,
  output logic                     rsp_done,
  output logic [LANES*WORD_W-1:0]  rsp_rdata
);

  localparam int unsigned BSEL_W = $clog2(BANKS);
  localparam int unsigned ROW_W  = ADDR_W - BSEL_W;
  localparam int unsigned ROWS   = 1 << ROW_W;
  localparam int unsigned LIDX_W = $clog2(LANES);

  logic rst_q;

  sp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_q)
  );

  sp_state_e                    state_q, state_n;
  logic [LANES-1:0]             pend_q, pend_n;
  logic [LANES-1:0][WORD_W-1:0] rdata_q, rdata_n;
  logic                         done_q, done_n;

  logic [LANES-1:0]             wr_q;
  logic [LANES-1:0][ADDR_W-1:0] addr_q;
  logic [LANES-1:0][WORD_W-1:0] wdata_q;

  logic                         accept;
  logic [LANES-1:0]             served;

  logic [BANKS-1:0]             hit_b;
  logic [BANKS-1:0]             we_b;
  logic [LIDX_W-1:0]            lead_b  [BANKS];
  logic [LANES-1:0]             grant_b [BANKS];
  logic [ROW_W-1:0]             row_b   [BANKS];
  logic [WORD_W-1:0]            rd_b    [BANKS];

  assign req_ready = rst_q && (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // one picker and one storage bank per bank index
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sp_bank_pick #(
      .LANES    (LANES),
      .ADDR_W   (ADDR_W),
      .BSEL_W   (BSEL_W),
      .BANK_IDX (b)
    ) u_pick (
      .pend  (pend_q),
      .addr  (addr_q),
      .is_wr (wr_q),
      .hit   (hit_b[b]),
      .lead  (lead_b[b]),
      .grant (grant_b[b]),
      .row   (row_b[b])
    );

    assign we_b[b] = (state_q == ST_SERVE) && hit_b[b] && wr_q[lead_b[b]];

    sp_bank_mem #(
      .ROWS   (ROWS),
      .WORD_W (WORD_W)
    ) u_mem (
      .clk   (clk),
      .we    (we_b[b]),
      .row   (row_b[b]),
      .wdata (wdata_q[lead_b[b]]),
      .rdata (rd_b[b])
    );
  end

  // union of lanes served by all banks this cycle
  always_comb begin
    served = '0;
    for (int b = 0; b < BANKS; b++) begin
      served = served | grant_b[b];
    end
  end

  // next-state logic
  always_comb begin
    state_n = state_q;
    pend_n  = pend_q;
    rdata_n = rdata_q;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_n = ST_SERVE;
          pend_n  = req_lane_en;
          rdata_n = '0;
        end
      end
      ST_SERVE: begin
        pend_n = pend_q & ~served;
        for (int l = 0; l < LANES; l++) begin
          if (served[l] && !wr_q[l]) begin
            rdata_n[l] = rd_b[addr_q[l][BSEL_W-1:0]];
          end
        end
        if (pend_n == '0) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // control and result registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      rdata_q <= rdata_n;
      done_q  <= done_n;
    end
  end

  // group capture registers, enabled on acceptance only
  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q  <= req_addr;
      wr_q    <= req_is_wr & req_lane_en;
      wdata_q <= req_wdata;
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sp_scratchpad_chk.sv
module sp_scratchpad_chk #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned WORD_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    rsp_done,
  input logic [LANES-1:0]        pend_q,
  input logic [LANES*WORD_W-1:0] rsp_rdata
);

  logic [7:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (req_valid && req_ready) begin
      busy_cnt <= '0;
    end else if (!req_ready) begin
      busy_cnt <= busy_cnt + 8'd1;
    end
  end

  // R7
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R7
  done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R4
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (pend_q == '0));

  // R4
  serve_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= 8'(LANES));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_ready) && !$past(req_valid)) |-> $stable(rsp_rdata));

endmodule

bind sp_scratchpad sp_scratchpad_chk #(
  .LANES  (LANES),
  .WORD_W (WORD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .pend_q    (pend_q),
  .rsp_rdata (rsp_rdata)
);

// File: tb/tb_sp_scratchpad.sv
`timescale 1ns/1ps
module tb_sp_scratchpad;

  localparam int LANES = 16;
  localparam int W     = 32;
  localparam int AW    = 8;
  localparam int NVEC  = 13;

  // vector: base[36:29] stride[28:21] lane mask[20:5] expected cycles[4:0]
  localparam logic [36:0] VEC [NVEC] = '{
    {8'd0,   8'd1,  16'hFFFF, 5'd1},   // R5 stride 1
    {8'd5,   8'd3,  16'hFFFF, 5'd1},   // R5 odd stride
    {8'd9,   8'd7,  16'hFFFF, 5'd1},   // R5 odd stride
    {8'd0,   8'd2,  16'hFFFF, 5'd2},   // R5 stride 2
    {8'd1,   8'd4,  16'hFFFF, 5'd4},   // R5 stride 4
    {8'd0,   8'd8,  16'hFFFF, 5'd8},   // R5 stride 8
    {8'd3,   8'd16, 16'hFFFF, 5'd16},  // R5 stride 16
    {8'd200, 8'd16, 16'hFFFF, 5'd16},  // R1 wrap
    {8'd77,  8'd0,  16'hFFFF, 5'd1},   // R3 broadcast
    {8'd0,   8'd2,  16'h00FF, 5'd1},   // R8 half group
    {8'd0,   8'd8,  16'h0101, 5'd2},   // R8 sparse conflict
    {8'd0,   8'd32, 16'h8001, 5'd2},   // R4 first and last lane
    {8'd40,  8'd16, 16'h0000, 5'd1}    // R8 empty group
  };

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  req_valid;
  logic                  req_ready;
  logic [LANES-1:0]      req_lane_en;
  logic [LANES-1:0]      req_is_wr;
  logic [LANES*AW-1:0]   req_addr;
  logic [LANES*W-1:0]    req_wdata;
  logic                  rsp_done;
  logic [LANES*W-1:0]    rsp_rdata;

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0]  model   [256];
  logic [AW-1:0] g_addr  [LANES];
  logic [W-1:0]  g_wdata [LANES];

  always #4 clk = ~clk;

  sp_scratchpad dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_lane_en (req_lane_en),
    .req_is_wr   (req_is_wr),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata)
  );

  function automatic logic [W-1:0] pat(input logic [AW-1:0] a);
    return {8'hC3, a, ~a, a ^ 8'h5A};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // called at a falling edge; returns service cycles until done
  task automatic run_group(input logic [LANES-1:0] en, input logic [LANES-1:0] wr,
                           output int cyc);
    int guard;
    guard = 0;
    while (!req_ready && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    req_valid   = 1'b1;
    req_lane_en = en;
    req_is_wr   = wr;
    for (int l = 0; l < LANES; l++) begin
      req_addr[l*AW +: AW] = g_addr[l];
      req_wdata[l*W +: W]  = g_wdata[l];
    end
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic chk_rd(input logic [LANES-1:0] en, input logic [LANES-1:0] wr,
                        input string req);
    logic [W-1:0] exp;
    for (int l = 0; l < LANES; l++) begin
      exp = (en[l] && !wr[l]) ? model[g_addr[l]] : '0;
      chk(rsp_rdata[l*W +: W] == exp, $sformatf("%s lane %0d", req, l),
          64'(rsp_rdata[l*W +: W]), 64'(exp));
    end
  endtask

  task automatic model_write(input logic [LANES-1:0] en, input logic [LANES-1:0] wr);
    for (int l = 0; l < LANES; l++) begin
      if (en[l] && wr[l]) model[g_addr[l]] = g_wdata[l];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    bit low_ok;
    logic [LANES*W-1:0] saved;

    rst_n       = 1'b1;
    req_valid   = 1'b0;
    req_lane_en = '0;
    req_is_wr   = '0;
    req_addr    = '0;
    req_wdata   = '0;
    for (int l = 0; l < LANES; l++) begin
      g_addr[l]  = '0;
      g_wdata[l] = '0;
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b0, "R10 ready in reset", 64'(req_ready), 64'd0);
    chk(rsp_done == 1'b0, "R10 done in reset", 64'(rsp_done), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_done == 1'b0, "R10 done after reset", 64'(rsp_done), 64'd0);
    chk(rsp_rdata == '0, "R10 rdata after reset", 64'(rsp_rdata[63:0]), 64'd0);

    // fill all words: group g writes row g of every bank (R1, R2)
    for (int g = 0; g < 16; g++) begin
      for (int l = 0; l < LANES; l++) begin
        g_addr[l]  = AW'(g * 16 + l);
        g_wdata[l] = pat(AW'(g * 16 + l));
      end
      run_group('1, '1, cyc);
      chk(cyc == 1, $sformatf("R2 fill group %0d cycles", g), 64'(cyc), 64'd1);
      chk_rd('1, '1, "R8 write lanes zero");
      model_write('1, '1);
    end

    // table of stride patterns (R1 R3 R4 R5 R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [AW-1:0]    base, stride;
      logic [LANES-1:0] mask;
      int               ecyc;
      base   = VEC[v][36:29];
      stride = VEC[v][28:21];
      mask   = VEC[v][20:5];
      ecyc   = int'(VEC[v][4:0]);
      for (int l = 0; l < LANES; l++) begin
        g_addr[l] = AW'(base + stride * AW'(l));
      end
      run_group(mask, '0, cyc);
      chk(cyc == ecyc, $sformatf("R4 R5 vec %0d cycles", v), 64'(cyc), 64'(ecyc));
      chk_rd(mask, '0, $sformatf("R1 R3 R8 vec %0d", v));
    end

    // R4 broadcast merged with a same-bank conflict
    for (int l = 0; l < LANES; l++) g_addr[l] = 8'd0;
    g_addr[0] = 8'd17;
    g_addr[1] = 8'd17;
    g_addr[2] = 8'd33;
    run_group(16'h0007, '0, cyc);
    chk(cyc == 2, "R4 merge plus conflict cycles", 64'(cyc), 64'd2);
    chk_rd(16'h0007, '0, "R4 merge plus conflict");

    // R6 two lanes write one word
    g_addr[3]  = 8'd50;
    g_addr[9]  = 8'd50;
    g_wdata[3] = 32'h1111_0003;
    g_wdata[9] = 32'h9999_0009;
    run_group(16'h0208, 16'h0208, cyc);
    chk(cyc == 2, "R6 duplicate write cycles", 64'(cyc), 64'd2);
    model[50] = 32'h9999_0009;
    g_addr[0] = 8'd50;
    run_group(16'h0001, '0, cyc);
    chk(rsp_rdata[W-1:0] == 32'h9999_0009, "R6 higher lane wins",
        64'(rsp_rdata[W-1:0]), 64'h9999_0009);

    // R8 mix of reads, inactive lanes and writes in separate banks
    for (int l = 0; l < LANES; l++) begin
      g_addr[l]  = (l < 8) ? AW'(l) : AW'(192 + l);
      g_wdata[l] = 32'hA0A0_0000 | 32'(l);
    end
    run_group(16'hF0FF, 16'hF000, cyc);
    chk(cyc == 1, "R8 mixed group cycles", 64'(cyc), 64'd1);
    chk_rd(16'hF0FF, 16'hF000, "R8 mixed group");
    model_write(16'hF0FF, 16'hF000);
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(192 + l);
    run_group('1, '0, cyc);
    chk_rd('1, '0, "R8 mixed writes landed");

    // R9 pulse width and hold of results
    saved = rsp_rdata;
    @(negedge clk);
    chk(rsp_done == 1'b0, "R9 done one cycle", 64'(rsp_done), 64'd0);
    repeat (3) @(negedge clk);
    chk(rsp_rdata == saved, "R9 rdata held", 64'(rsp_rdata[63:0]), 64'(saved[63:0]));

    // R11 two same-bank groups back to back, each one cycle
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(l);
    run_group('1, '0, cyc);
    chk(cyc == 1, "R11 first group cycles", 64'(cyc), 64'd1);
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(16 + l);
    run_group('1, '0, cyc);
    chk(cyc == 1, "R11 second group cycles", 64'(cyc), 64'd1);
    chk_rd('1, '0, "R11 second group data");

    // R7 request while busy is ignored
    for (int l = 0; l < LANES; l++) g_addr[l] = AW'(l * 16);
    while (!req_ready) @(negedge clk);
    req_valid   = 1'b1;
    req_lane_en = '1;
    req_is_wr   = '0;
    for (int l = 0; l < LANES; l++) req_addr[l*AW +: AW] = g_addr[l];
    @(negedge clk);
    req_lane_en        = 16'h0001;
    req_is_wr          = 16'h0001;
    req_addr[AW-1:0]   = 8'd0;
    req_wdata[W-1:0]   = 32'hDEAD_BEEF;
    cyc    = 0;
    low_ok = 1'b1;
    while (!rsp_done && cyc < 100) begin
      if (req_ready) low_ok = 1'b0;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(low_ok, "R7 ready low while busy", 64'(low_ok), 64'd1);
    chk(cyc == 16, "R7 busy group cycles", 64'(cyc), 64'd16);
    chk_rd('1, '0, "R7 busy group data");
    @(negedge clk);
    g_addr[0] = 8'd0;
    run_group(16'h0001, '0, cyc);
    chk(rsp_rdata[W-1:0] == model[0], "R7 ignored write",
        64'(rsp_rdata[W-1:0]), 64'(model[0]));

    summary();
    $finish;
  end

endmodule